// File: doc/BRIEF.md
# Machine Timer with Per-Hart Compare

This block is the machine-level timer shared by a group of harts. It keeps one 64-bit time value visible to software and, for each hart, a 64-bit compare register. Each hart gets its own timer interrupt line. That line is raised while the time value is at or above the hart's compare value, taken as unsigned numbers.

The time value is not a loadable counter. Internally a raw tick count advances by one on every enable pulse from a timebase input. A stored 64-bit offset is added to that count to form the visible time. Writing the time only rewrites the offset, so counting carries on upward from whatever software wrote. Software reaches the registers through a single-request interface. Each request is a 32-bit or a naturally aligned 64-bit access, and read data comes back one cycle after the request.

The register map has a fixed layout. The compare register for hart `i` is at byte offset `8*i`, with its low half at `8*i` and its high half at `8*i+4`. The time register is at offset `0x7FF8`, with its high half at `0x7FFC`. Both registers are little-endian.

Top module: `hart_timer_top`

## Requirements
- R1: After reset, time reads 0. Every compare register reads all ones. Every interrupt line is low and `rspValid` is low.
- R2: While no time write is taken, time rises by exactly one on each cycle with `tickEn` high and holds on each cycle with `tickEn` low.
- R3: A 32-bit write to offset `0x7FF8` replaces only the low half of time, and a 32-bit write to `0x7FFC` replaces only the high half. The other half keeps its live value at the moment of the write. The written data is taken from `wdata[31:0]`.
- R4: A 64-bit write (`reqWide`=1) to `0x7FF8` loads all of `wdata` into time in one cycle. Time reads exactly that value on the next cycle, whatever `tickEn` was during the write, and counts on from it.
- R5: The compare register of hart `i` (`i` < `NUM_HARTS`) is at offset `8*i`. A 32-bit write to `8*i` changes only bits 31:0, and a 32-bit write to `8*i+4` changes only bits 63:32. A 64-bit write to `8*i` loads the whole register.
- R6: `timerIrq[i]` is a register. On each clock edge it takes the result of (time >= compare of hart `i`, unsigned) computed from the state held before that edge.
- R7: A time write updates every hart's compare result. An interrupt line can rise or fall purely because time was rewritten.
- R8: Every read request gives `rspValid`=1 on the next cycle, and `rspValid` is 0 on every other cycle. A 64-bit read returns the full register. A 32-bit read returns the addressed half in `rdata[31:0]` with `rdata[63:32]`=0.
- R9: The following accesses are unmapped: offsets that are neither time nor a compare register of an existing hart, 64-bit accesses with address bits 2:0 nonzero, and 32-bit accesses with address bits 1:0 nonzero. Unmapped reads return 0 and unmapped writes change nothing.
- R10: Time may be written to a value below its current value, using wrap-around 64-bit arithmetic. Counting then continues upward from the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Timebase pulse; advances the raw tick count |
| reqValid | input | 1 | Access request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| reqAddr | input | 15 | Byte offset inside the block |
| wdata | input | 64 | Write data; 32-bit writes use bits 31:0 |
| rspValid | output | 1 | Read data valid (one cycle after a read request) |
| rdata | output | 64 | Read data |
| timerIrq | output | NUM_HARTS | Machine timer interrupt, one per hart |

## Verification
A write changes time and compare state at the clock edge that accepts it. Read data and `rspValid` belong to the edge after the request, and each interrupt line trails the state by one more edge. The bench drives every request just after a falling edge. Before the rising edge it computes from its reference model both the read value and the interrupt vector expected from the pre-edge state. It then advances the model at the rising edge and compares everything at the following falling edge. As a result, each interrupt check uses the model state from one edge earlier, while read data is checked against the value held when the request was issued.

// File: rtl/hart_timer_pkg.sv
package hart_timer_pkg;
  localparam int TIME_W = 64;
  localparam int HALF_W = TIME_W / 2;
  localparam int ADDR_W = 15;
  localparam int IDX_W  = ADDR_W - 3;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_TIME = 2'd1,
    SRC_CMP  = 2'd2
  } src_e;

  typedef struct packed {
    logic             timeLo;
    logic             timeHi;
    logic             cmpLo;
    logic             cmpHi;
    logic             wide;
    logic             rdEn;
    src_e             rdSrc;
    logic             rdWide;
    logic             rdHigh;
    logic [IDX_W-1:0] idx;
  } strobe_t;
endpackage

// File: rtl/hart_timer_ctrl.sv
module hart_timer_ctrl
  import hart_timer_pkg::*;
#(
  parameter int NUM_HARTS = 4
) (
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqWide,
  input  logic [ADDR_W-1:0] reqAddr,
  output strobe_t           stb
);
  logic [IDX_W-1:0] word;
  logic aligned, isTime, isCmp, hit, loSel, hiSel;

  assign word    = reqAddr[ADDR_W-1:3];
  assign aligned = reqWide ? (reqAddr[2:0] == 3'd0) : (reqAddr[1:0] == 2'd0);
  assign isTime  = (word == {IDX_W{1'b1}});
  assign isCmp   = !isTime && (32'(word) < NUM_HARTS);
  assign hit     = reqValid && aligned;
  assign loSel   = reqWide || !reqAddr[2];
  assign hiSel   = reqWide || reqAddr[2];

  always_comb begin
    stb        = '0;
    stb.idx    = word;
    stb.wide   = reqWide;
    stb.rdWide = reqWide;
    stb.rdHigh = reqAddr[2];
    stb.rdEn   = reqValid && !reqWrite;
    stb.rdSrc  = SRC_NONE;
    if (hit && reqWrite) begin
      if (isTime) begin
        stb.timeLo = loSel;
        stb.timeHi = hiSel;
      end else if (isCmp) begin
        stb.cmpLo = loSel;
        stb.cmpHi = hiSel;
      end
    end
    if (hit && !reqWrite) begin
      if (isTime)     stb.rdSrc = SRC_TIME;
      else if (isCmp) stb.rdSrc = SRC_CMP;
    end
  end
endmodule

// File: rtl/hart_timer_cmp.sv
module hart_timer_cmp
  import hart_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrLo,
  input  logic              wrHi,
  input  logic [HALF_W-1:0] loData,
  input  logic [HALF_W-1:0] hiData,
  input  logic [TIME_W-1:0] timeNow,
  output logic [TIME_W-1:0] cmpVal,
  output logic              irq
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpVal <= '1;
      irq    <= 1'b0;
    end else begin
      if (wrLo) cmpVal[HALF_W-1:0]      <= loData;
      if (wrHi) cmpVal[TIME_W-1:HALF_W] <= hiData;
      irq <= (timeNow >= cmpVal);
    end
  end
endmodule

// File: rtl/hart_timer_dp.sv
module hart_timer_dp
  import hart_timer_pkg::*;
#(
  parameter int NUM_HARTS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickEn,
  input  strobe_t              stb,
  input  logic [TIME_W-1:0]    wdata,
  output logic [TIME_W-1:0]    timeNow,
  output logic [NUM_HARTS-1:0] irq,
  output logic                 rspValid,
  output logic [TIME_W-1:0]    rdata
);
  logic [TIME_W-1:0] base, delta, baseNext, newTime, selVal, rdNext;
  logic [HALF_W-1:0] hiData;
  logic [TIME_W-1:0] cmpVal [NUM_HARTS];

  assign hiData   = stb.wide ? wdata[TIME_W-1:HALF_W] : wdata[HALF_W-1:0];
  assign timeNow  = base + delta;
  assign baseNext = base + {{(TIME_W-1){1'b0}}, tickEn};
  assign newTime  = {stb.timeHi ? hiData : timeNow[TIME_W-1:HALF_W],
                     stb.timeLo ? wdata[HALF_W-1:0] : timeNow[HALF_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      base  <= '0;
      delta <= '0;
    end else begin
      base <= baseNext;
      if (stb.timeLo || stb.timeHi) delta <= newTime - baseNext;
    end
  end

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
    logic sel;
    assign sel = (stb.idx == IDX_W'(h));
    hart_timer_cmp u_cmp (
      .clk     (clk),
      .rstN    (rstN),
      .wrLo    (stb.cmpLo && sel),
      .wrHi    (stb.cmpHi && sel),
      .loData  (wdata[HALF_W-1:0]),
      .hiData  (hiData),
      .timeNow (timeNow),
      .cmpVal  (cmpVal[h]),
      .irq     (irq[h])
    );
  end

  always_comb begin
    selVal = '0;
    case (stb.rdSrc)
      SRC_TIME: selVal = timeNow;
      SRC_CMP: begin
        for (int i = 0; i < NUM_HARTS; i++)
          if (stb.idx == IDX_W'(i)) selVal = cmpVal[i];
      end
      default: selVal = '0;
    endcase
    if (stb.rdWide) rdNext = selVal;
    else rdNext = {{HALF_W{1'b0}},
                   stb.rdHigh ? selVal[TIME_W-1:HALF_W] : selVal[HALF_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rdata    <= '0;
    end else begin
      rspValid <= stb.rdEn;
      rdata    <= stb.rdEn ? rdNext : '0;
    end
  end
endmodule

// File: rtl/hart_timer_top.sv
module hart_timer_top
  import hart_timer_pkg::*;
#(
  parameter int NUM_HARTS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickEn,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic                 reqWide,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [TIME_W-1:0]    wdata,
  output logic                 rspValid,
  output logic [TIME_W-1:0]    rdata,
  output logic [NUM_HARTS-1:0] timerIrq
);
  strobe_t           stb;
  logic [TIME_W-1:0] timeNow;

  hart_timer_ctrl #(.NUM_HARTS(NUM_HARTS)) u_ctrl (
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqWide  (reqWide),
    .reqAddr  (reqAddr),
    .stb      (stb)
  );

  hart_timer_dp #(.NUM_HARTS(NUM_HARTS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .stb      (stb),
    .wdata    (wdata),
    .timeNow  (timeNow),
    .irq      (timerIrq),
    .rspValid (rspValid),
    .rdata    (rdata)
  );
endmodule

// File: rtl/hart_timer_chk.sv
module hart_timer_chk
  import hart_timer_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic              reqValid,
  input logic              reqWrite,
  input logic [TIME_W-1:0] wdata,
  input strobe_t           stb,
  input logic [TIME_W-1:0] timeNow,
  input logic              rspValid
);
  logic timeWr, cmpWr;
  assign timeWr = stb.timeLo || stb.timeHi;
  assign cmpWr  = stb.cmpLo || stb.cmpHi;

  assert_tick_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!timeWr && tickEn) |=> (timeNow == $past(timeNow) + 64'd1));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!timeWr && !tickEn) |=> $stable(timeNow));

  assert_wide_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.timeLo && stb.timeHi) |=> (timeNow == $past(wdata)));

  assert_keep_high_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.timeLo && !stb.timeHi) |=>
      (timeNow == {$past(timeNow[TIME_W-1:HALF_W]), $past(wdata[HALF_W-1:0])}));

  assert_keep_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.timeHi && !stb.timeLo) |=>
      (timeNow == {$past(wdata[HALF_W-1:0]), $past(timeNow[HALF_W-1:0])}));

  assert_read_rsp_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite) |=> rspValid);

  assert_no_rsp_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && !reqWrite) |=> !rspValid);

  assert_one_target_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(timeWr && cmpWr));

  assert_read_no_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    !reqWrite |-> !(timeWr || cmpWr));
endmodule

bind hart_timer_top hart_timer_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .tickEn   (tickEn),
  .reqValid (reqValid),
  .reqWrite (reqWrite),
  .wdata    (wdata),
  .stb      (stb),
  .timeNow  (timeNow),
  .rspValid (rspValid)
);

// File: tb/hart_timer_top_test.sv
`timescale 1ns/1ps
module hart_timer_top_test;
  localparam int NH = 4;
  localparam logic [14:0] T_LO = 15'h7FF8;
  localparam logic [14:0] T_HI = 15'h7FFC;

  logic clk = 1'b0;
  logic rstN, tickEn, reqValid, reqWrite, reqWide;
  logic [14:0] reqAddr;
  logic [63:0] wdata;
  logic rspValid;
  logic [63:0] rdata;
  logic [NH-1:0] timerIrq;

  int checks = 0;
  int errors = 0;

  logic [63:0] mTime;
  logic [63:0] mCmp [NH];

  always #2.5 clk = ~clk;

  hart_timer_top #(.NUM_HARTS(NH)) uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqWide(reqWide), .reqAddr(reqAddr),
    .wdata(wdata), .rspValid(rspValid), .rdata(rdata), .timerIrq(timerIrq)
  );

  task automatic check(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // 0 = unmapped, 1 = time, 2 = compare
  function automatic int decode(input logic [14:0] a, input logic wide, output int h);
    h = 0;
    if (wide && a[2:0] != 3'd0) return 0;
    if (!wide && a[1:0] != 2'd0) return 0;
    if (a[14:3] == 12'hFFF) return 1;
    if (int'(a[14:3]) < NH) begin h = int'(a[14:3]); return 2; end
    return 0;
  endfunction

  function automatic logic [63:0] modelRead(input logic [14:0] a, input logic wide);
    int h, k;
    logic [63:0] v;
    k = decode(a, wide, h);
    if (k == 0) return 64'd0;
    v = (k == 1) ? mTime : mCmp[h];
    if (wide) return v;
    return a[2] ? {32'd0, v[63:32]} : {32'd0, v[31:0]};
  endfunction

  task automatic modelWrite(input logic [14:0] a, input logic wide, input logic [63:0] d,
                            output logic wroteTime);
    int h, k;
    logic [63:0] v;
    wroteTime = 1'b0;
    k = decode(a, wide, h);
    if (k == 0) return;
    v = (k == 1) ? mTime : mCmp[h];
    if (wide) v = d;
    else if (a[2]) v[63:32] = d[31:0];
    else v[31:0] = d[31:0];
    if (k == 1) begin mTime = v; wroteTime = 1'b1; end
    else mCmp[h] = v;
  endtask

  task automatic step(input logic v, input logic w, input logic wide,
                      input logic [14:0] a, input logic [63:0] d, input logic tick,
                      input string tag);
    logic [NH-1:0] irqExp;
    logic [63:0] rdExp;
    logic wrote;
    reqValid = v; reqWrite = w; reqWide = wide; reqAddr = a; wdata = d; tickEn = tick;
    for (int i = 0; i < NH; i++) irqExp[i] = (mTime >= mCmp[i]);
    rdExp = modelRead(a, wide);
    @(posedge clk);
    wrote = 1'b0;
    if (v && w) modelWrite(a, wide, d, wrote);
    if (!wrote && tick) mTime = mTime + 64'd1;
    @(negedge clk);
    reqValid = 1'b0; tickEn = 1'b0;
    check(timerIrq == irqExp, "R6 irq", 64'(timerIrq), 64'(irqExp));
    check(rspValid == (v && !w), "R8 rspValid", 64'(rspValid), 64'(v && !w));
    if (v && !w) check(rdata == rdExp, tag, rdata, rdExp);
  endtask

  task automatic idle(input int n, input logic tick);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 15'd0, 64'd0, tick, "idle");
  endtask

  function automatic logic [14:0] cmpAddr(input int h, input logic hi);
    return 15'(8 * h + (hi ? 4 : 0));
  endfunction

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; tickEn = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; reqWide = 1'b0;
    reqAddr = '0; wdata = '0;
    mTime = 64'd0;
    for (int i = 0; i < NH; i++) mCmp[i] = '1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    check(timerIrq == '0, "R1 irq after reset", 64'(timerIrq), 64'd0);
    check(rspValid == 1'b0, "R1 rspValid after reset", 64'(rspValid), 64'd0);
    step(1, 0, 1, T_LO, 0, 0, "R1 time reset value");
    for (int h = 0; h < NH; h++) step(1, 0, 1, cmpAddr(h, 0), 0, 0, "R1 compare reset value");

    // R2: counting and holding
    idle(5, 1);
    idle(3, 0);
    step(1, 0, 1, T_LO, 0, 0, "R2 count after five ticks");
    step(1, 0, 1, T_LO, 0, 1, "R2 read while ticking");

    // R4: atomic wide write, carry across halves afterwards
    step(1, 1, 1, T_LO, 64'h0000_0001_FFFF_FFF0, 1, "R4 wide write");
    step(1, 0, 1, T_LO, 0, 0, "R4 value right after wide write");
    idle(20, 1);
    step(1, 0, 0, T_LO, 0, 0, "R4 low half after carry");
    step(1, 0, 0, T_HI, 0, 0, "R4 high half after carry");

    // R3: half writes keep the live other half
    idle(4, 1);
    step(1, 1, 0, T_LO, 64'h0000_0000_0000_0010, 1, "R3 low half write");
    step(1, 0, 1, T_LO, 0, 0, "R3 high half kept");
    step(1, 1, 0, T_HI, 64'h0000_0000_0000_ABCD, 1, "R3 high half write");
    idle(3, 1);
    step(1, 0, 1, T_LO, 0, 0, "R3 low half kept and counting");

    // R5: compare halves
    step(1, 1, 0, cmpAddr(2, 0), 64'hFFFF_FFFF_0000_1234, 0, "R5 cmp low write");
    step(1, 0, 1, cmpAddr(2, 0), 0, 0, "R5 cmp low only");
    step(1, 1, 0, cmpAddr(2, 1), 64'h0000_0000_0000_0000, 0, "R5 cmp high write");
    step(1, 0, 1, cmpAddr(2, 0), 0, 0, "R5 cmp high only");
    step(1, 1, 1, cmpAddr(3, 0), 64'h1122_3344_5566_7788, 0, "R5 cmp wide write");
    step(1, 0, 1, cmpAddr(3, 0), 0, 0, "R5 cmp wide readback");

    // R7 / R10: rewriting time moves interrupts both ways
    step(1, 1, 1, cmpAddr(1, 0), 64'd100, 0, "R7 cmp setup");
    step(1, 1, 1, T_LO, 64'd200, 0, "R7 time above compare");
    idle(1, 0);
    check(timerIrq[1] == 1'b1, "R7 irq rises after time write", 64'(timerIrq[1]), 64'd1);
    step(1, 1, 1, T_LO, 64'd50, 1, "R10 smaller time write");
    idle(1, 0);
    check(timerIrq[1] == 1'b0, "R7 irq falls after time write", 64'(timerIrq[1]), 64'd0);
    idle(7, 1);
    step(1, 0, 1, T_LO, 0, 0, "R10 counting from smaller value");
    check(rdata == 64'd57, "R10 exact value", rdata, 64'd57);

    // R9: unmapped and misaligned accesses
    step(1, 1, 1, cmpAddr(NH, 0), 64'hDEAD, 0, "R9 write past last hart");
    step(1, 1, 0, 15'h0100, 64'hBEEF, 0, "R9 write unmapped");
    step(1, 1, 1, T_HI, 64'hFFFF_0000_FFFF_0000, 0, "R9 misaligned wide time write");
    step(1, 1, 0, 15'h0002, 64'h5555, 0, "R9 misaligned narrow cmp write");
    step(1, 0, 1, T_LO, 0, 0, "R9 time unchanged");
    step(1, 0, 1, cmpAddr(0, 0), 0, 0, "R9 cmp0 unchanged");
    step(1, 0, 1, cmpAddr(NH, 0), 0, 0, "R9 read past last hart");
    step(1, 0, 0, 15'h7FF0, 0, 0, "R9 read unmapped");
    step(1, 0, 1, T_HI, 0, 0, "R9 misaligned wide read");
    step(1, 0, 0, 15'h7FF9, 0, 0, "R9 misaligned narrow read");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int op, h;
      logic tk;
      logic [63:0] d;
      op = int'($urandom_range(0, 11));
      h  = int'($urandom_range(0, NH - 1));
      tk = 1'($urandom_range(0, 1));
      d  = {$urandom, $urandom};
      case (op)
        0: step(1, 0, 1, T_LO, 0, tk, "R8 random wide time read");
        1: step(1, 0, 0, $urandom_range(0, 1) ? T_HI : T_LO, 0, tk, "R8 random half time read");
        2: step(1, 0, 1, cmpAddr(h, 0), 0, tk, "R5 random cmp read");
        3: step(1, 0, 0, cmpAddr(h, $urandom_range(0, 1) == 1), 0, tk, "R5 random cmp half read");
        4: step(1, 1, 1, cmpAddr(h, 0), mTime + 64'($urandom_range(0, 30)), tk, "R5 random cmp write");
        5: step(1, 1, 0, cmpAddr(h, 0), 64'(mTime[31:0] + 32'($urandom_range(0, 30))), tk, "R5 random cmp low write");
        6: step(1, 1, 1, T_LO, mCmp[h] - 64'($urandom_range(0, 20)) + 64'd10, tk, "R4 random time write");
        7: step(1, 1, 0, T_LO, {32'd0, d[31:0]}, tk, "R3 random low time write");
        8: step(1, 1, 0, T_HI, {32'd0, mCmp[h][63:32]}, tk, "R3 random high time write");
        9: step(1, $urandom_range(0, 1) == 1, 1'($urandom_range(0, 1)),
                15'(8 * NH + 8 * $urandom_range(0, 100)), d, tk, "R9 random unmapped");
        default: step(0, 0, 0, 0, 0, tk, "idle");
      endcase
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule